// File: doc/BRIEF.md
# Biphase Line Bit Recovery

This block turns a biphase-coded serial line into a stream of recovered bits. The line arrives as a single-ended logic level, asynchronous to the fast system clock. Inside the block it is synchronised and passed to an edge detector. A controller with two states then follows the line. In `ST_IDLE` it waits for activity. The first edge it sees moves it to `ST_TRACK` (the transition *wake*) and marks the first bit boundary. From then on a phase counter runs at the nominal bit period, which is 32 µs at 31.25 kbit/s. The line level is read a quarter of a period after each boundary, and that level is the bit value.

Every bit boundary on the line carries a transition. An edge that arrives close to an expected boundary pulls the phase counter back into step with the line. This absorbs the drift between the transmitter's clock and the local clock. Edges in the middle of a bit are not used for timing. If the line stays quiet for several bit periods, the transition *timeout* returns the controller to `ST_IDLE`. The block then reports loss of signal, and the next edge starts a fresh first boundary. Byte framing and the electrical receiver sit outside this block.

Top module: `biphase_rx`

## Requirements
- R1: While reset is held and right after it, `bit_valid`, `busy` and `sig_lost` are 0.
- R2: In `ST_IDLE`, the first change of `line_in` is taken as a bit boundary, and `busy` rises in the third clock cycle after that change. The delay comes from two synchroniser flops plus the state register.
- R3: Each recovered bit has `bit_data` equal to the level of `line_in` one quarter period after its boundary. `bit_valid` is first seen QUARTER+3 cycles after the boundary change on `line_in`.
- R4: `bit_valid` is high for exactly one clock cycle per recovered bit.
- R5: A line edge that falls within SLACK cycles of an expected boundary, early or late, resets the phase to that edge. The bit that follows is then timed from that edge as in R3.
- R6: An edge outside the boundary window neither moves the phase nor produces a bit. A boundary with no edge inside its window yields no `bit_valid`.
- R7: If no edge occurs for QUIET_BITS×PERIOD cycles in `ST_TRACK`, the block returns to `ST_IDLE`. `busy` falls QUIET_BITS×PERIOD+3 cycles after the last line change, and `sig_lost` pulses high for one cycle in the same cycle that `busy` falls.
- R8: After a timeout, the next edge is taken as a new first boundary, with the latencies of R2 and R3.
- R9: The counts are derived at elaboration as PERIOD = CLK_HZ/BIT_HZ, QUARTER = PERIOD/4 and SLACK = PERIOD/8, each using integer division.
- R10: `bit_valid` is asserted only while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | 1 | Biphase line level, asynchronous |
| bit_valid | output | 1 | One-cycle strobe for each recovered bit |
| bit_data | output | 1 | Recovered bit value, meaningful with `bit_valid` |
| busy | output | 1 | High while the controller is in `ST_TRACK` |
| sig_lost | output | 1 | One-cycle pulse when a timeout returns the block to idle |

## Verification
All 256 byte values are sent as one continuous stream. This covers the data patterns with and without a mid-bit edge, so it shows that the value comes from the quarter-period level and not from which edges are present. Frames are then sent with every bit offset by each skew from −SLACK to +SLACK. These show that drift inside the window is absorbed, with the strobe latency unchanged. Alternating patterns skewed by one cycle beyond the window, early and late, show that out-of-window edges produce no bits. A lone edge followed by silence checks the wake latency, the exact cycle of the timeout, and the re-arm for the next frame.

// File: rtl/bpr_pkg.sv
`timescale 1ns/1ps
package bpr_pkg;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_TRACK = 1'b1
    } rx_state_e;

    function automatic int cycles_per_bit(input int clk_hz, input int bit_hz);
        return clk_hz / bit_hz;
    endfunction

endpackage

// File: rtl/bpr_sync.sv
`timescale 1ns/1ps
module bpr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic lvl,
    output logic tog
);
    logic [STAGES-1:0] chain;
    logic              held;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
            held  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], din};
            held  <= chain[STAGES-1];
        end
    end

    assign lvl = chain[STAGES-1];
    assign tog = chain[STAGES-1] ^ held;
endmodule

// File: rtl/bpr_phase.sv
`timescale 1ns/1ps
module bpr_phase #(
    parameter int PERIOD  = 1600,
    parameter int QUARTER = 400,
    parameter int SLACK   = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic at_quarter,
    output logic in_window
);
    localparam int W = $clog2(PERIOD);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= W'(1);
        end else if (!run) begin
            cnt <= '0;
        end else if (cnt == W'(PERIOD - 1)) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + W'(1);
        end
    end

    assign at_quarter = (cnt == W'(QUARTER));
    assign in_window  = (cnt <= W'(SLACK)) || (cnt >= W'(PERIOD - SLACK));
endmodule

// File: rtl/bpr_quiet.sv
`timescale 1ns/1ps
module bpr_quiet #(
    parameter int LIMIT = 6400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clear,
    output logic expired
);
    localparam int W = $clog2(LIMIT);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || clear) begin
            cnt <= '0;
        end else if (!expired) begin
            cnt <= cnt + W'(1);
        end
    end

    assign expired = (cnt == W'(LIMIT - 1));
endmodule

// File: rtl/biphase_rx.sv
`timescale 1ns/1ps
module biphase_rx
    import bpr_pkg::*;
#(
    parameter int CLK_HZ      = 50_000_000,
    parameter int BIT_HZ      = 31_250,
    parameter int SYNC_STAGES = 2,
    parameter int QUIET_BITS  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic bit_valid,
    output logic bit_data,
    output logic busy,
    output logic sig_lost
);
    localparam int PERIOD  = cycles_per_bit(CLK_HZ, BIT_HZ);
    localparam int QUARTER = PERIOD / 4;
    localparam int SLACK   = PERIOD / 8;
    localparam int QUIET   = PERIOD * QUIET_BITS;

    rx_state_e state, state_nx;
    logic      lvl, tog, at_q, in_win, expired;
    logic      accept, armed, sample, tracking;

    bpr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (line_in),
        .lvl   (lvl),
        .tog   (tog)
    );

    assign tracking = (state == ST_TRACK);
    assign accept   = tog && (!tracking || in_win);
    assign sample   = tracking && at_q && armed;

    bpr_phase #(.PERIOD(PERIOD), .QUARTER(QUARTER), .SLACK(SLACK)) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (tracking),
        .restart    (accept),
        .at_quarter (at_q),
        .in_window  (in_win)
    );

    bpr_quiet #(.LIMIT(QUIET)) u_quiet (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (tracking),
        .clear   (tog),
        .expired (expired)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (tog)                state_nx = ST_TRACK;
            ST_TRACK: if (expired && !tog)    state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed     <= 1'b0;
            bit_valid <= 1'b0;
            bit_data  <= 1'b0;
            sig_lost  <= 1'b0;
        end else begin
            bit_valid <= sample;
            sig_lost  <= tracking && (state_nx == ST_IDLE);
            if (sample) bit_data <= lvl;
            if (accept)                armed <= 1'b1;
            else if (sample || !tracking) armed <= 1'b0;
        end
    end

    assign busy = tracking;
endmodule

// File: rtl/bpr_checker.sv
`timescale 1ns/1ps
module bpr_checker (
    input logic clk,
    input logic rst_n,
    input logic tog,
    input logic busy,
    input logic bit_valid,
    input logic sig_lost
);
    assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |=> !bit_valid);

    assert_strobe_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |-> busy);

    assert_lost_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sig_lost |-> (!busy && $past(busy)));

    assert_lost_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sig_lost |-> !$past(tog));

    assert_wake_on_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(tog));
endmodule

bind biphase_rx bpr_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tog       (tog),
    .busy      (busy),
    .bit_valid (bit_valid),
    .sig_lost  (sig_lost)
);

// File: tb/tb_biphase_rx.sv
`timescale 1ns/1ps
module tb_biphase_rx;
    localparam int P   = 32;
    localparam int Q   = P / 4;
    localparam int T   = P / 8;
    localparam int TMO = 4 * P;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line = 1'b0;
    logic bit_valid, bit_data, busy, sig_lost;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    int last_edge = 0;
    int exp_b[$];
    int exp_t[$];
    bit sbits[$];
    bit prev_valid = 1'b0;

    biphase_rx #(.CLK_HZ(1_000_000), .BIT_HZ(31_250)) dut (
        .clk(clk), .rst_n(rst_n), .line_in(line),
        .bit_valid(bit_valid), .bit_data(bit_data),
        .busy(busy), .sig_lost(sig_lost)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s at cycle %0d: got %0d expected %0d", req, cyc, act, expv);
        end
    endtask

    // monitor: value and latency of each strobe (R3, R9), width (R4), busy (R10)
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_valid) chk(!bit_valid, "R4 strobe width", int'(bit_valid), 0);
            if (bit_valid) begin
                chk(busy === 1'b1, "R10 strobe while busy", int'(busy), 1);
                if (exp_b.size() == 0) begin
                    chk(1'b0, "R6 unexpected bit", 1, 0);
                end else begin
                    int eb, et;
                    eb = exp_b.pop_front();
                    et = exp_t.pop_front();
                    chk(int'(bit_data) == eb, "R3 bit value", int'(bit_data), eb);
                    chk(cyc == et + Q + 3, "R3_R9 strobe latency", cyc - et, Q + 3);
                end
            end
        end
        prev_valid = bit_valid;
    end

    task automatic set_line(input bit v);
        if (v !== line) last_edge = cyc;
        line = v;
    endtask

    task automatic send_stream(input int d, input bit only_first);
        for (int i = 0; i < sbits.size(); i++) begin
            bit b, nb;
            b  = sbits[i];
            nb = (i + 1 < sbits.size()) ? sbits[i+1] : ~b;
            set_line(b);
            if (!only_first || i == 0) begin
                exp_b.push_back(int'(b));
                exp_t.push_back(cyc);
            end
            repeat (P / 2) @(negedge clk);
            set_line(~nb);
            repeat (P / 2 + d) @(negedge clk);
        end
    endtask

    task automatic wait_idle();
        int target;
        target = last_edge + TMO + 3;
        while (cyc < target - 1) @(negedge clk);
        chk(busy === 1'b1, "R7 busy before timeout", int'(busy), 1);
        @(negedge clk);
        chk(busy === 1'b0, "R7 busy after timeout", int'(busy), 0);
        chk(sig_lost === 1'b1, "R7 loss pulse", int'(sig_lost), 1);
        @(negedge clk);
        chk(sig_lost === 1'b0, "R7 loss pulse width", int'(sig_lost), 0);
        chk(exp_b.size() == 0, "R6 missing bits", exp_b.size(), 0);
        repeat (5) @(negedge clk);
    endtask

    task automatic push_byte(input logic [7:0] v);
        for (int k = 0; k < 8; k++) sbits.push_back(v[k]);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        chk(bit_valid === 1'b0, "R1 reset strobe", int'(bit_valid), 0);
        chk(busy === 1'b0, "R1 reset busy", int'(busy), 0);
        chk(sig_lost === 1'b0, "R1 reset loss", int'(sig_lost), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(busy === 1'b0, "R1 idle after reset", int'(busy), 0);

        // lone edge: wake latency, one bit, timeout
        begin
            int n;
            n = cyc;
            set_line(1'b1);
            exp_b.push_back(1);
            exp_t.push_back(n);
            @(negedge clk);
            @(negedge clk);
            chk(busy === 1'b0, "R2 busy not early", int'(busy), 0);
            @(negedge clk);
            chk(busy === 1'b1, "R2 busy after wake", int'(busy), 1);
        end
        wait_idle();

        // every byte value in one continuous stream, re-armed after timeout (R8)
        sbits.delete();
        sbits.push_back(~line);
        for (int v = 0; v < 256; v++) begin
            push_byte(8'(v));
            sbits.push_back(1'b1);
        end
        send_stream(0, 1'b0);
        wait_idle();

        // skew sweep inside the window (R5)
        for (int d = -T; d <= T; d++) begin
            sbits.delete();
            sbits.push_back(~line);
            push_byte(8'hA5);
            push_byte(8'h3C);
            send_stream(d, 1'b0);
            wait_idle();
        end

        // one cycle beyond the window, late then early (R6)
        for (int s = 0; s < 2; s++) begin
            int d;
            d = (s == 0) ? (T + 1) : -(T + 1);
            sbits.delete();
            for (int i = 0; i < 4; i++) sbits.push_back((i % 2 == 0) ? ~line : line);
            send_stream(d, 1'b1);
            wait_idle();
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog (R1-wide run) got %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule